// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the 32-bit base-ISA word that does the same work. A fetch or decode stage feeds it the halfword. One clock later it returns the expanded word and a flag that marks the halfword as illegal or reserved. When the flag is set, the returned word is all zeros. Downstream logic then decodes only the base encoding and never has to handle the compressed forms.

Decoding works in layers. The two low bits pick the quadrant, and each quadrant has its own sub-decoder. Inside a quadrant, bits 15:13 pick the operation. Bits 11:10, bit 12 and bits 6:5 split the arithmetic groups further. The scattered immediate bits of each form are gathered, zero- or sign-extended, and placed where the I, S, B, U or J format expects them. The 3-bit register fields address x8 to x15.

The `XLEN` parameter selects the variant, 32 or 64. The 64-bit variant adds the word-sized add-immediate, the doubleword loads, the word add and subtract, and 6-bit shift amounts.

Top module: `rvc_expand`

## Requirements
- R1: While reset is asserted, the expanded word is 0 and the illegal flag is 0, whatever the input.
- R2: The outputs reflect the halfword sampled at the previous rising clock edge: exactly one cycle of latency.
- R3: A halfword with bits 1:0 equal to 11 is not compressed. It gives illegal = 1 and word = 0, and every illegal result gives word 0.
- R4: Quadrant 0 (bits 1:0 = 00) expands the following forms, and a stack-pointer add whose 8-bit immediate is zero (this includes the all-zero halfword) is illegal:
  - stack-pointer add, funct3 000: `addi rd', x2, uimm`, with uimm scaled by 4.
  - word load, funct3 010: `lw`.
  - word store, funct3 110: `sw`.
  - The 3-bit register fields map to x8+field.
- R5: Quadrant 1 expands the following forms:
  - funct3 000 to `addi rd, rd, simm6`.
  - funct3 010 to `addi rd, x0, simm6`.
  - funct3 100 with bits 11:10 = 10 to `andi`.
  - funct3 100 with bits 11:10 = 00 to `srli`, and = 01 to `srai` (funct6 010000).
- R6: Quadrant 1, funct3 011 works as follows:
  - With rd = x2, it gives `addi x2, x2, nzimm`, with nzimm a multiple of 16 in the range -512 to 496.
  - With any other rd, it gives `lui rd, nzimm`, with a sign-extended 6-bit upper immediate.
  - A zero immediate is illegal in both forms.
- R7: Quadrant 1, funct3 100, bits 11:10 = 11 and bit 12 = 0 select an operation with bits 6:5:
  - 00 selects `sub`, 01 `xor`, 10 `or` and 11 `and`, on rd', rd', rs2'.
  - With bit 12 = 1, bits 6:5 = 00 give `subw` and 01 gives `addw`, in the 64-bit variant only. All other cases are illegal.
- R8: Quadrant 1 covers the jumps and branches:
  - funct3 101 gives `jal x0`, and funct3 001 in the 32-bit variant gives `jal x1`, each with the reassembled, sign-extended 12-bit offset.
  - funct3 110 gives `beq rs1', x0` and funct3 111 gives `bne rs1', x0`, each with the sign-extended 9-bit offset.
- R9: Quadrant 2 covers the shift and stack-relative forms:
  - funct3 000 gives `slli rd, rd, shamt`.
  - funct3 010 gives `lw rd, uimm(x2)`. rd = x0 is illegal.
  - funct3 110 gives `sw rs2, uimm(x2)`.
- R10: Quadrant 2, funct3 100 is decoded as follows:
  - Bit 12 = 0 with rs2 = 0 gives `jalr x0, 0(rs1)`, and rs1 = x0 is illegal. With rs2 ≠ 0 it gives `add rd, x0, rs2`.
  - Bit 12 = 1 with rs1 = rs2 = 0 gives `ebreak` (0x00100073). With only rs2 = 0 it gives `jalr x1, 0(rs1)`. Otherwise it gives `add rd, rd, rs2`.
- R11: In the 32-bit variant, any shift-immediate form with bit 12 set (shift amount ≥ 32) is illegal.
- R12: The 64-bit variant handles these forms:
  - Quadrant 1, funct3 001 gives `addiw rd, rd, simm6`. rd = x0 is illegal.
  - Quadrant 0, funct3 011 gives `ld`.
  - Quadrant 2, funct3 011 gives `ld rd, uimm(x2)`, and rd = x0 is illegal.
  - Shift amounts use 6 bits.
- R13: The following slots are illegal in both variants:
  - Quadrant 0, funct3 001, 100, 101 and 111.
  - Quadrant 2, funct3 001, 101 and 111.
  - funct3 011 in quadrants 0 and 2 in the 32-bit variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cinsn_i | input | 16 | Compressed instruction halfword |
| insn_o | output | 32 | Expanded base instruction, zero when illegal |
| illegal_o | output | 1 | Halfword is illegal or reserved |

## Verification
Every one of the 65,536 halfwords is applied back to back, one per cycle, to a 32-bit and a 64-bit instance at the same time. Each result is compared with an expansion computed in the bench by adding up bit weights, which is a different method from the bit reordering used in the RTL. Applying the same word to both instances separates the width-dependent slots (funct3 001 and 011, the word operations and shift amounts of 32 and above) from the shared ones. The full sweep also reaches every reserved corner, such as zero immediates and rd = x0 in a load. A few hand-encoded words (no-op, load-immediate -1, register move, breakpoint, jump through x0, word subtract) pin the expected results to known constants. One check holds the input steady across a cycle to separate the one-cycle latency from a combinational path.

// File: rtl/rvc_exp_pkg.sv
package rvc_exp_pkg;

    localparam int CW = 16;
    localparam int IW = 32;

    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [6:0] OPC_OP      = 7'b0110011;
    localparam logic [6:0] OPC_OP32    = 7'b0111011;
    localparam logic [6:0] OPC_LUI     = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
    localparam logic [6:0] OPC_JALR    = 7'b1100111;
    localparam logic [6:0] OPC_JAL     = 7'b1101111;

    localparam logic [IW-1:0] BREAK_WORD = 32'h0010_0073;

    // expansion result: base word plus illegal marker
    typedef struct packed {
        logic [IW-1:0] word;
        logic          bad;
    } xp_t;

    localparam xp_t XP_BAD = '{word: '0, bad: 1'b1};

    function automatic xp_t xp_ok(input logic [IW-1:0] w);
        return '{word: w, bad: 1'b0};
    endfunction

    // 3-bit register field addresses x8..x15
    function automatic logic [4:0] creg(input logic [2:0] r);
        return {2'b01, r};
    endfunction

    function automatic logic [IW-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                            input logic [2:0] f3, input logic [4:0] rd,
                                            input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [IW-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3,
                                            input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    function automatic logic [IW-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
    endfunction

    function automatic logic [IW-1:0] enc_b(input logic [12:1] off, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3);
        return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], OPC_BRANCH};
    endfunction

    function automatic logic [IW-1:0] enc_u(input logic [19:0] imm, input logic [4:0] rd,
                                            input logic [6:0] opc);
        return {imm, rd, opc};
    endfunction

    function automatic logic [IW-1:0] enc_j(input logic [20:1] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
    endfunction

endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
    import rvc_exp_pkg::*;
#(
    parameter bit WIDE64 = 1'b0
) (
    input  logic [CW-1:2] c_i,
    output xp_t           x_o
);

    logic [2:0] f3;
    logic [4:0] r_lo;
    logic [4:0] r_hi;
    logic [9:0] uimm_sp;
    logic [6:0] uimm_w;
    logic [7:0] uimm_d;

    assign f3      = c_i[15:13];
    assign r_lo    = creg(c_i[4:2]);
    assign r_hi    = creg(c_i[9:7]);
    // [9:6] [5:4] [3] [2] [1:0]
    assign uimm_sp = {c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
    // [6] [5:3] [2] [1:0]
    assign uimm_w  = {c_i[5], c_i[12:10], c_i[6], 2'b00};
    // [7:6] [5:3] [2:0]
    assign uimm_d  = {c_i[6:5], c_i[12:10], 3'b000};

    always_comb begin
        x_o = XP_BAD;
        case (f3)
            3'b000: begin
                if (uimm_sp != '0) begin
                    x_o = xp_ok(enc_i({2'b00, uimm_sp}, 5'd2, 3'b000, r_lo, OPC_OPIMM));
                end
            end
            3'b010: x_o = xp_ok(enc_i({5'b0, uimm_w}, r_hi, 3'b010, r_lo, OPC_LOAD));
            3'b011: begin
                if (WIDE64) begin
                    x_o = xp_ok(enc_i({4'b0, uimm_d}, r_hi, 3'b011, r_lo, OPC_LOAD));
                end
            end
            3'b110: x_o = xp_ok(enc_s({5'b0, uimm_w}, r_lo, r_hi, 3'b010));
            default: x_o = XP_BAD;
        endcase
    end

endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
    import rvc_exp_pkg::*;
#(
    parameter bit WIDE64 = 1'b0
) (
    input  logic [CW-1:2] c_i,
    output xp_t           x_o
);

    logic [2:0]  f3;
    logic [4:0]  r_full;
    logic [4:0] r_p1;
    logic [4:0] r_p2;
    logic [5:0]  imm6;
    logic [11:0] imm12;
    logic [9:4]  sp16;
    logic [11:1] jraw;
    logic [20:1] joff;
    logic [8:1]  braw;
    logic [12:1] boff;
    logic [1:0]  grp;
    logic [1:0]  sel;
    xp_t         slot1;

    assign f3     = c_i[15:13];
    assign r_full = c_i[11:7];
    assign r_p1   = creg(c_i[9:7]);
    assign r_p2   = creg(c_i[4:2]);
    assign imm6   = {c_i[12], c_i[6:2]};
    assign imm12  = {{6{c_i[12]}}, imm6};
    // [9] [8:7] [6] [5] [4]
    assign sp16   = {c_i[12], c_i[4:3], c_i[5], c_i[2], c_i[6]};
    // [11] [10] [9:8] [7] [6] [5] [4] [3:1]
    assign jraw   = {c_i[12], c_i[8], c_i[10:9], c_i[6], c_i[7], c_i[2], c_i[11], c_i[5:3]};
    assign joff   = {{9{c_i[12]}}, jraw};
    // [8] [7:6] [5] [4:3] [2:1]
    assign braw   = {c_i[12], c_i[6:5], c_i[2], c_i[11:10], c_i[4:3]};
    assign boff   = {{4{c_i[12]}}, braw};
    assign grp    = c_i[11:10];
    assign sel    = c_i[6:5];

    // funct3 001: word add-immediate in the wide variant, linked jump otherwise
    if (WIDE64) begin : g_addiw
        always_comb begin
            slot1 = XP_BAD;
            if (r_full != '0) begin
                slot1 = xp_ok(enc_i(imm12, r_full, 3'b000, r_full, OPC_OPIMM32));
            end
        end
    end else begin : g_jal
        assign slot1 = xp_ok(enc_j(joff, 5'd1));
    end

    always_comb begin
        x_o = XP_BAD;
        case (f3)
            3'b000: x_o = xp_ok(enc_i(imm12, r_full, 3'b000, r_full, OPC_OPIMM));
            3'b001: x_o = slot1;
            3'b010: x_o = xp_ok(enc_i(imm12, 5'd0, 3'b000, r_full, OPC_OPIMM));
            3'b011: begin
                if (r_full == 5'd2) begin
                    if (sp16 != '0) begin
                        x_o = xp_ok(enc_i({{2{c_i[12]}}, sp16, 4'b0000}, 5'd2, 3'b000,
                                          5'd2, OPC_OPIMM));
                    end
                end else if (imm6 != '0) begin
                    x_o = xp_ok(enc_u({{14{c_i[12]}}, imm6}, r_full, OPC_LUI));
                end
            end
            3'b100: begin
                case (grp)
                    2'b00: begin
                        if (WIDE64 || !c_i[12]) begin
                            x_o = xp_ok(enc_i({6'b000000, imm6}, r_p1, 3'b101, r_p1, OPC_OPIMM));
                        end
                    end
                    2'b01: begin
                        if (WIDE64 || !c_i[12]) begin
                            x_o = xp_ok(enc_i({6'b010000, imm6}, r_p1, 3'b101, r_p1, OPC_OPIMM));
                        end
                    end
                    2'b10: x_o = xp_ok(enc_i(imm12, r_p1, 3'b111, r_p1, OPC_OPIMM));
                    default: begin
                        if (!c_i[12]) begin
                            case (sel)
                                2'b00: x_o = xp_ok(enc_r(7'b0100000, r_p2, r_p1, 3'b000, r_p1, OPC_OP));
                                2'b01: x_o = xp_ok(enc_r(7'b0000000, r_p2, r_p1, 3'b100, r_p1, OPC_OP));
                                2'b10: x_o = xp_ok(enc_r(7'b0000000, r_p2, r_p1, 3'b110, r_p1, OPC_OP));
                                default: x_o = xp_ok(enc_r(7'b0000000, r_p2, r_p1, 3'b111, r_p1, OPC_OP));
                            endcase
                        end else if (WIDE64) begin
                            case (sel)
                                2'b00: x_o = xp_ok(enc_r(7'b0100000, r_p2, r_p1, 3'b000, r_p1, OPC_OP32));
                                2'b01: x_o = xp_ok(enc_r(7'b0000000, r_p2, r_p1, 3'b000, r_p1, OPC_OP32));
                                default: x_o = XP_BAD;
                            endcase
                        end
                    end
                endcase
            end
            3'b101: x_o = xp_ok(enc_j(joff, 5'd0));
            3'b110: x_o = xp_ok(enc_b(boff, 5'd0, r_p1, 3'b000));
            default: x_o = xp_ok(enc_b(boff, 5'd0, r_p1, 3'b001));
        endcase
    end

endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
    import rvc_exp_pkg::*;
#(
    parameter bit WIDE64 = 1'b0
) (
    input  logic [CW-1:2] c_i,
    output xp_t           x_o
);

    logic [2:0] f3;
    logic [4:0] r_full;
    logic [4:0] r_two;
    logic [5:0] shamt;
    logic [7:0] uimm_lw;
    logic [8:0] uimm_ld;
    logic [7:0] uimm_sw;

    assign f3      = c_i[15:13];
    assign r_full  = c_i[11:7];
    assign r_two   = c_i[6:2];
    assign shamt   = {c_i[12], c_i[6:2]};
    // [7:6] [5] [4:2] [1:0]
    assign uimm_lw = {c_i[3:2], c_i[12], c_i[6:4], 2'b00};
    // [8:6] [5] [4:3] [2:0]
    assign uimm_ld = {c_i[4:2], c_i[12], c_i[6:5], 3'b000};
    // [7:6] [5:2] [1:0]
    assign uimm_sw = {c_i[8:7], c_i[12:9], 2'b00};

    always_comb begin
        x_o = XP_BAD;
        case (f3)
            3'b000: begin
                if (WIDE64 || !c_i[12]) begin
                    x_o = xp_ok(enc_i({6'b000000, shamt}, r_full, 3'b001, r_full, OPC_OPIMM));
                end
            end
            3'b010: begin
                if (r_full != '0) begin
                    x_o = xp_ok(enc_i({4'b0, uimm_lw}, 5'd2, 3'b010, r_full, OPC_LOAD));
                end
            end
            3'b011: begin
                if (WIDE64 && (r_full != '0)) begin
                    x_o = xp_ok(enc_i({3'b0, uimm_ld}, 5'd2, 3'b011, r_full, OPC_LOAD));
                end
            end
            3'b100: begin
                if (!c_i[12]) begin
                    if (r_two == '0) begin
                        if (r_full != '0) begin
                            x_o = xp_ok(enc_i(12'd0, r_full, 3'b000, 5'd0, OPC_JALR));
                        end
                    end else begin
                        x_o = xp_ok(enc_r(7'd0, r_two, 5'd0, 3'b000, r_full, OPC_OP));
                    end
                end else begin
                    if ((r_two == '0) && (r_full == '0)) begin
                        x_o = xp_ok(BREAK_WORD);
                    end else if (r_two == '0) begin
                        x_o = xp_ok(enc_i(12'd0, r_full, 3'b000, 5'd1, OPC_JALR));
                    end else begin
                        x_o = xp_ok(enc_r(7'd0, r_two, r_full, 3'b000, r_full, OPC_OP));
                    end
                end
            end
            3'b110: x_o = xp_ok(enc_s({4'b0, uimm_sw}, r_two, 5'd2, 3'b010));
            default: x_o = XP_BAD;
        endcase
    end

endmodule

// File: rtl/rvc_expand.sv
module rvc_expand
    import rvc_exp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] cinsn_i,
    output logic [IW-1:0] insn_o,
    output logic          illegal_o
);

    localparam bit WIDE64 = (XLEN == 64);

    typedef struct packed {
        logic [IW-1:0] insn;
        logic          illegal;
        logic          live;
    } st_t;

    st_t st_d, st_q;
    xp_t x_q0, x_q1, x_q2;
    xp_t pick;

    rvc_quad0 #(.WIDE64(WIDE64)) i_quad0 (.c_i(cinsn_i[CW-1:2]), .x_o(x_q0));
    rvc_quad1 #(.WIDE64(WIDE64)) i_quad1 (.c_i(cinsn_i[CW-1:2]), .x_o(x_q1));
    rvc_quad2 #(.WIDE64(WIDE64)) i_quad2 (.c_i(cinsn_i[CW-1:2]), .x_o(x_q2));

    always_comb begin
        case (cinsn_i[1:0])
            2'b00:   pick = x_q0;
            2'b01:   pick = x_q1;
            2'b10:   pick = x_q2;
            default: pick = XP_BAD;
        endcase
        st_d         = st_q;
        st_d.insn    = pick.word;
        st_d.illegal = pick.bad;
        st_d.live    = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign insn_o    = st_q.insn;
    assign illegal_o = st_q.illegal;

    // R3: uncompressed quadrant flagged, word cleared
    a_r3_quadrant3_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.live && ($past(cinsn_i[1:0]) == 2'b11) |-> illegal_o && (insn_o == '0));

    // R3: every illegal result carries a zero word
    a_r3_bad_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (insn_o == '0));

    // R2: a legal result is always a full-width encoding
    a_r2_full_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.live && !illegal_o |-> (insn_o[1:0] == 2'b11));

    // R4: the all-zero halfword is illegal
    a_r4_zero_halfword: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.live && ($past(cinsn_i) == '0) |-> illegal_o);

    // R8: compressed branches become conditional branches
    a_r8_branch_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.live && ($past(cinsn_i[1:0]) == 2'b01) && ($past(cinsn_i[15:14]) == 2'b11)
        |-> !illegal_o && (insn_o[6:0] == OPC_BRANCH));

    // R10: breakpoint halfword
    a_r10_breakpoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.live && ($past(cinsn_i) == 16'h9002) |-> (insn_o == BREAK_WORD));

    // R11: wide shift amounts rejected in the narrow variant
    a_r11_narrow_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !WIDE64 && st_q.live && ($past(cinsn_i[1:0]) == 2'b01)
        && ($past(cinsn_i[15:13]) == 3'b100) && ($past(cinsn_i[11]) == 1'b0)
        && $past(cinsn_i[12]) |-> illegal_o);

endmodule

// File: tb/test_rvc_expand.sv
module test_rvc_expand;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cin = 16'h0000;
    logic [31:0] w32, w64;
    logic        b32, b64;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rvc_expand #(.XLEN(32)) i_rvc_expand (
        .clk_i(clk), .rst_ni(rst_n), .cinsn_i(cin), .insn_o(w32), .illegal_o(b32));

    rvc_expand #(.XLEN(64)) i_rvc_expand_w64 (
        .clk_i(clk), .rst_ni(rst_n), .cinsn_i(cin), .insn_o(w64), .illegal_o(b64));

    function automatic logic [31:0] mk_i(input int imm, input int rs1, input int f3,
                                         input int rd, input int op);
        logic [31:0] x;
        x = imm;
        return {x[11:0], 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction

    function automatic logic [31:0] mk_s(input int imm, input int rs2, input int rs1, input int f3);
        logic [31:0] x;
        x = imm;
        return {x[11:5], 5'(rs2), 5'(rs1), 3'(f3), x[4:0], 7'h23};
    endfunction

    function automatic logic [31:0] mk_r(input int f7, input int rs2, input int rs1,
                                         input int f3, input int rd, input int op);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction

    function automatic logic [31:0] mk_u(input int imm, input int rd);
        logic [31:0] x;
        x = imm;
        return {x[19:0], 5'(rd), 7'h37};
    endfunction

    function automatic logic [31:0] mk_b(input int off, input int rs1, input int f3);
        logic [31:0] x;
        x = off;
        return {x[12], x[10:5], 5'd0, 5'(rs1), 3'(f3), x[4:1], x[11], 7'h63};
    endfunction

    function automatic logic [31:0] mk_j(input int off, input int rd);
        logic [31:0] x;
        x = off;
        return {x[20], x[10:1], x[11], x[19:12], 5'(rd), 7'h6f};
    endfunction

    // reference expansion: {illegal, word}, immediates summed from bit weights
    function automatic logic [32:0] model(input logic [15:0] c, input bit wide);
        int q, f, rd, rs2, rp, rq, simm, u, sh, off;
        bit ok;
        logic [31:0] w;
        q    = int'(c[1:0]);
        f    = int'(c[15:13]);
        rd   = int'(c[11:7]);
        rs2  = int'(c[6:2]);
        rp   = 8 + int'(c[9:7]);
        rq   = 8 + int'(c[4:2]);
        simm = int'(c[6:2]) - (c[12] ? 32 : 0);
        sh   = int'(c[6:2]) + (c[12] ? 32 : 0);
        ok   = 1'b0;
        w    = 32'h0;
        if (q == 0) begin
            case (f)
                0: begin
                    u = int'(c[12:11]) * 16 + int'(c[10:7]) * 64 + int'(c[6]) * 4 + int'(c[5]) * 8;
                    if (u != 0) begin ok = 1'b1; w = mk_i(u, 2, 0, rq, 'h13); end
                end
                2: begin
                    u = int'(c[12:10]) * 8 + int'(c[6]) * 4 + int'(c[5]) * 64;
                    ok = 1'b1; w = mk_i(u, rp, 2, rq, 'h03);
                end
                3: if (wide) begin
                    u = int'(c[12:10]) * 8 + int'(c[6:5]) * 64;
                    ok = 1'b1; w = mk_i(u, rp, 3, rq, 'h03);
                end
                6: begin
                    u = int'(c[12:10]) * 8 + int'(c[6]) * 4 + int'(c[5]) * 64;
                    ok = 1'b1; w = mk_s(u, rq, rp, 2);
                end
                default: ok = 1'b0;
            endcase
        end else if (q == 1) begin
            off = int'(c[5:3]) * 2 + int'(c[11]) * 16 + int'(c[2]) * 32 + int'(c[7]) * 64
                + int'(c[6]) * 128 + int'(c[10:9]) * 256 + int'(c[8]) * 1024 - (c[12] ? 2048 : 0);
            case (f)
                0: begin ok = 1'b1; w = mk_i(simm, rd, 0, rd, 'h13); end
                1: begin
                    if (wide) begin
                        if (rd != 0) begin ok = 1'b1; w = mk_i(simm, rd, 0, rd, 'h1b); end
                    end else begin
                        ok = 1'b1; w = mk_j(off, 1);
                    end
                end
                2: begin ok = 1'b1; w = mk_i(simm, 0, 0, rd, 'h13); end
                3: begin
                    if (rd == 2) begin
                        u = int'(c[6]) * 16 + int'(c[2]) * 32 + int'(c[5]) * 64
                          + int'(c[4:3]) * 128 - (c[12] ? 512 : 0);
                        if (u != 0) begin ok = 1'b1; w = mk_i(u, 2, 0, 2, 'h13); end
                    end else if (simm != 0) begin
                        ok = 1'b1; w = mk_u(simm, rd);
                    end
                end
                4: begin
                    case (int'(c[11:10]))
                        0, 1: if (wide || sh < 32) begin
                            ok = 1'b1; w = mk_i(sh + (c[10] ? 1024 : 0), rp, 5, rp, 'h13);
                        end
                        2: begin ok = 1'b1; w = mk_i(simm, rp, 7, rp, 'h13); end
                        default: begin
                            if (!c[12]) begin
                                ok = 1'b1;
                                case (int'(c[6:5]))
                                    0: w = mk_r(32, rq, rp, 0, rp, 'h33);
                                    1: w = mk_r(0, rq, rp, 4, rp, 'h33);
                                    2: w = mk_r(0, rq, rp, 6, rp, 'h33);
                                    default: w = mk_r(0, rq, rp, 7, rp, 'h33);
                                endcase
                            end else if (wide && !c[6]) begin
                                ok = 1'b1; w = mk_r(c[5] ? 0 : 32, rq, rp, 0, rp, 'h3b);
                            end
                        end
                    endcase
                end
                5: begin ok = 1'b1; w = mk_j(off, 0); end
                default: begin
                    u = int'(c[4:3]) * 2 + int'(c[11:10]) * 8 + int'(c[2]) * 32
                      + int'(c[6:5]) * 64 - (c[12] ? 256 : 0);
                    ok = 1'b1; w = mk_b(u, rp, (f == 6) ? 0 : 1);
                end
            endcase
        end else if (q == 2) begin
            case (f)
                0: if (wide || sh < 32) begin ok = 1'b1; w = mk_i(sh, rd, 1, rd, 'h13); end
                2: if (rd != 0) begin
                    u = int'(c[6:4]) * 4 + int'(c[12]) * 32 + int'(c[3:2]) * 64;
                    ok = 1'b1; w = mk_i(u, 2, 2, rd, 'h03);
                end
                3: if (wide && rd != 0) begin
                    u = int'(c[6:5]) * 8 + int'(c[12]) * 32 + int'(c[4:2]) * 64;
                    ok = 1'b1; w = mk_i(u, 2, 3, rd, 'h03);
                end
                4: begin
                    if (!c[12]) begin
                        if (rs2 == 0) begin
                            if (rd != 0) begin ok = 1'b1; w = mk_i(0, rd, 0, 0, 'h67); end
                        end else begin
                            ok = 1'b1; w = mk_r(0, rs2, 0, 0, rd, 'h33);
                        end
                    end else begin
                        ok = 1'b1;
                        if (rs2 == 0 && rd == 0) w = 32'h0010_0073;
                        else if (rs2 == 0) w = mk_i(0, rd, 0, 1, 'h67);
                        else w = mk_r(0, rs2, rd, 0, rd, 'h33);
                    end
                end
                6: begin
                    u = int'(c[12:9]) * 4 + int'(c[8:7]) * 64;
                    ok = 1'b1; w = mk_s(u, rs2, 2, 2);
                end
                default: ok = 1'b0;
            endcase
        end
        return ok ? {1'b0, w} : {1'b1, 32'h0};
    endfunction

    function automatic string req_of(input logic [15:0] c, input bit wide);
        int f;
        f = int'(c[15:13]);
        case (int'(c[1:0]))
            0: begin
                if (f == 3) return wide ? "R12" : "R13";
                if (f == 0 || f == 2 || f == 6) return "R4";
                return "R13";
            end
            1: begin
                if (f == 1) return wide ? "R12" : "R8";
                if (f == 3) return "R6";
                if (f >= 5) return "R8";
                if (f == 4) begin
                    if (c[11:10] == 2'b11) return "R7";
                    if (!c[11] && c[12]) return wide ? "R12" : "R11";
                end
                return "R5";
            end
            2: begin
                if (f == 0) return (c[12] && !wide) ? "R11" : "R9";
                if (f == 2 || f == 6) return "R9";
                if (f == 3) return wide ? "R12" : "R13";
                if (f == 4) return "R10";
                return "R13";
            end
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] gw, input logic gb,
                         input logic [32:0] exp);
        checks++;
        if ({gb, gw} !== exp) begin
            errors++;
            $display("FAIL %s: got illegal=%0b word=%08h, expected illegal=%0b word=%08h",
                     tag, gb, gw, exp[32], exp[31:0]);
        end
    endtask

    // drive at a falling edge, sample after the next rising edge
    task automatic apply_hand(input string tag, input logic [15:0] c,
                              input logic [32:0] e32, input logic [32:0] e64);
        @(negedge clk);
        cin = c;
        @(negedge clk);
        check({tag, " (32)"}, w32, b32, e32);
        check({tag, " (64)"}, w64, b64, e64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: run did not complete, got timeout, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] prv;
        // R1: reset state, with a legal word on the input
        cin = 16'h557D;
        repeat (3) @(negedge clk);
        check("R1 reset (32)", w32, b32, 33'h0);
        check("R1 reset (64)", w64, b64, 33'h0);
        rst_n = 1'b1;

        // hand-encoded words
        apply_hand("R5 nop", 16'h0001, {1'b0, 32'h0000_0013}, {1'b0, 32'h0000_0013});
        apply_hand("R5 li x10,-1", 16'h557D, {1'b0, 32'hFFF0_0513}, {1'b0, 32'hFFF0_0513});
        apply_hand("R10 mv x1,x2", 16'h808A, {1'b0, 32'h0020_00B3}, {1'b0, 32'h0020_00B3});
        apply_hand("R10 ebreak", 16'h9002, {1'b0, 32'h0010_0073}, {1'b0, 32'h0010_0073});
        apply_hand("R10 jr x0 reserved", 16'h8002, {1'b1, 32'h0}, {1'b1, 32'h0});
        apply_hand("R4 zero halfword", 16'h0000, {1'b1, 32'h0}, {1'b1, 32'h0});
        apply_hand("R7 subw width", 16'h9C05, {1'b1, 32'h0}, {1'b0, 32'h4094_043B});
        apply_hand("R3 uncompressed", 16'h0013, {1'b1, 32'h0}, {1'b1, 32'h0});

        // R2: input changes at a falling edge, output still holds previous result
        @(negedge clk);
        cin = 16'h0001;
        @(negedge clk);
        cin = 16'h9002;
        #1;
        check("R2 latency hold", w32, b32, {1'b0, 32'h0000_0013});
        @(negedge clk);
        check("R2 latency update", w32, b32, {1'b0, 32'h0010_0073});

        // exhaustive sweep, one word per cycle, checked one cycle later
        prv = 16'h0;
        for (int v = 0; v < 65536; v++) begin
            @(negedge clk);
            if (v > 0) begin
                check(req_of(prv, 1'b0), w32, b32, model(prv, 1'b0));
                check(req_of(prv, 1'b1), w64, b64, model(prv, 1'b1));
            end
            cin = 16'(v);
            prv = 16'(v);
        end
        @(negedge clk);
        check(req_of(prv, 1'b0), w32, b32, model(prv, 1'b0));
        check(req_of(prv, 1'b1), w64, b64, model(prv, 1'b1));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule